// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a free-running watchdog counter driven by the system clock. A two-bit select field picks one of four time-out lengths. When the count reaches the chosen length, a sticky interrupt flag is raised. A fixed number of clocks later, the count ends its period. If the reset function is enabled, a single-clock CPU reset request is issued at that point and a status bit records that the reset came from the watchdog. Software holds off the reset by restarting the count before the period runs out.

Two control fields are protected against stray writes: the reset enable and the restart request. A control write applies them only inside a short window that opens after a two-byte key arrives on consecutive cycles at a separate key port. The other fields of a control write always take effect: the select, the interrupt enable, and the flag and status clears. The interrupt path works whether or not the reset is enabled. With the reset disabled, the counter wraps at the end of each period, so the flag recurs at a fixed rate and the block can serve as a periodic time base.

The default parameters give time-outs of 2^17, 2^20, 2^23 and 2^26 clocks and a gap of 512 clocks from interrupt to reset. The exponent base, the exponent step and the gap are all parameters.

Top module: `wdt_pre_irq`

## Requirements
- R1: After rst_ni is released, irq_o, irq_flag_o, cpu_rst_o, wd_rst_stat_o and rst_en_o are all 0. The active select is 00 and the count starts at zero, so irq_flag_o first rises 2^BASE_EXP clocks after release.
- R2: The select field sel_i of an accepted restart sets the time-out T to 2^(BASE_EXP + sel_i*EXP_STEP) clocks: 00, 01, 10 and 11 give the 1st, 2nd, 3rd and 4th lengths. irq_flag_o rises exactly T clocks after the restart edge.
- R3: irq_o is high exactly when irq_flag_o is set and the interrupt enable is 1. The flag is set at the time-out even while the interrupt enable is 0. The interrupt enable is loaded from irq_en_i by every control write.
- R4: irq_flag_o stays set until a control write with flag_clr_i = 1 arrives. If the clear lands on the same clock as the time-out, the flag stays set.
- R5: With the reset enabled, cpu_rst_o pulses high for exactly one clock, T + GAP_CLKS clocks after the restart edge. The count then returns to zero, so the next flag rises T clocks after the pulse.
- R6: wd_rst_stat_o is set on the same clock as the watchdog reset pulse. It stays set until a control write with stat_clr_i = 1 arrives.
- R7: With the reset disabled, no pulse is issued. The count wraps at T + GAP_CLKS, so the flag, once cleared, rises again one full period after the previous time-out.
- R8: Writing 0xAA and then 0x55 on key_data_i on consecutive clocks opens a window. A control write may change rst_en_i or restart_i only on one of the 4 clocks after the 0x55 clock. Outside the window both fields are ignored. Any control write closes the window.
- R9: A key sequence with an idle clock between 0xAA and 0x55, or with the bytes in reverse order, opens no window.
- R10: Writing a new select without an accepted restart leaves the current period unchanged. A restart request outside the window does not restart the count.
- R11: An accepted restart that lands on the clock on which the reset would fire wins. No pulse is issued, the status bit stays clear, and the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_we_i | input | 1 | Key register write strobe |
| key_data_i | input | 8 | Key byte |
| ctrl_we_i | input | 1 | Control register write strobe |
| sel_i | input | 2 | Time-out select, loaded on restart |
| irq_en_i | input | 1 | Interrupt enable |
| rst_en_i | input | 1 | Reset enable (protected) |
| restart_i | input | 1 | Restart the count (protected) |
| flag_clr_i | input | 1 | Clear the interrupt flag |
| stat_clr_i | input | 1 | Clear the watchdog reset status |
| irq_o | output | 1 | Interrupt request |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| cpu_rst_o | output | 1 | One-clock CPU reset request |
| wd_rst_stat_o | output | 1 | Last reset came from the watchdog |
| rst_en_o | output | 1 | Current reset enable |

## Verification
The case that matters is a software restart landing on the very clock on which the reset would fire. The bench times an unlock and a restart so that the write reaches the final count. It then expects no pulse, a clear status bit, and a fresh flag exactly one time-out later. A second collision pits a flag clear against the time-out on the same clock. Here the flag must remain set and must clear only on a later write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned N_SEL    = 1 << SEL_W;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam int unsigned WIN_CLKS = 4;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int unsigned WIN = WIN_CLKS
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_we_i,
  input  logic [7:0] key_data_i,
  input  logic       ctrl_we_i,
  output logic       open_o
);
  localparam int unsigned WIN_W = $clog2(WIN + 1);

  logic             first_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      win_q   <= '0;
    end else begin
      first_q <= key_we_i && (key_data_i == KEY_A);
      if (key_we_i && (key_data_i == KEY_B) && first_q)
        win_q <= WIN_W'(WIN);
      else if (ctrl_we_i)
        win_q <= '0;  // any control write consumes the window
      else if (win_q != '0)
        win_q <= win_q - WIN_W'(1);
    end
  end

  assign open_o = (win_q != '0);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 17,
  parameter int unsigned EXP_STEP = 3,
  parameter int unsigned GAP_CLKS = 512,
  parameter int unsigned CNT_W    = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rst_en_i,
  input  logic             flag_clr_i,
  input  logic             stat_clr_i,
  output logic             flag_o,
  output logic             rst_pulse_o,
  output logic             stat_o
);
  logic [CNT_W-1:0] irq_last [N_SEL];
  logic [CNT_W-1:0] end_last [N_SEL];

  for (genvar g = 0; g < N_SEL; g++) begin : g_lim
    localparam int unsigned SH = BASE_EXP + g * EXP_STEP;
    assign irq_last[g] = (CNT_W'(1) << SH) - CNT_W'(1);
    assign end_last[g] = (CNT_W'(1) << SH) + CNT_W'(GAP_CLKS - 1);
  end

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_act_q;
  logic             irq_hit, end_hit, fire;

  assign irq_hit = !restart_i && (cnt_q == irq_last[sel_act_q]);
  assign end_hit = (cnt_q == end_last[sel_act_q]);
  assign fire    = !restart_i && end_hit && rst_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sel_act_q   <= '0;
      flag_o      <= 1'b0;
      rst_pulse_o <= 1'b0;
      stat_o      <= 1'b0;
    end else begin
      if (restart_i) begin
        cnt_q     <= '0;
        sel_act_q <= sel_i;
      end else if (end_hit) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      rst_pulse_o <= fire;
      if (irq_hit)         flag_o <= 1'b1;  // set wins over clear
      else if (flag_clr_i) flag_o <= 1'b0;
      if (fire)            stat_o <= 1'b1;
      else if (stat_clr_i) stat_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_pre_irq.sv
module wdt_pre_irq
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 17,
  parameter int unsigned EXP_STEP = 3,
  parameter int unsigned GAP_CLKS = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_we_i,
  input  logic [7:0] key_data_i,
  input  logic       ctrl_we_i,
  input  logic [1:0] sel_i,
  input  logic       irq_en_i,
  input  logic       rst_en_i,
  input  logic       restart_i,
  input  logic       flag_clr_i,
  input  logic       stat_clr_i,
  output logic       irq_o,
  output logic       irq_flag_o,
  output logic       cpu_rst_o,
  output logic       wd_rst_stat_o,
  output logic       rst_en_o
);
  localparam int unsigned CNT_W = BASE_EXP + (N_SEL - 1) * EXP_STEP + 1;

  logic unlocked, prot_ok, restart_go;
  logic irq_en_q, rst_en_q;

  wdt_unlock #(.WIN(WIN_CLKS)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_we_i  (key_we_i),
    .key_data_i(key_data_i),
    .ctrl_we_i (ctrl_we_i),
    .open_o    (unlocked)
  );

  assign prot_ok    = ctrl_we_i && unlocked;
  assign restart_go = prot_ok && restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      rst_en_q <= 1'b0;
    end else begin
      if (ctrl_we_i) irq_en_q <= irq_en_i;
      if (prot_ok)   rst_en_q <= rst_en_i;
    end
  end

  wdt_timer #(
    .BASE_EXP(BASE_EXP),
    .EXP_STEP(EXP_STEP),
    .GAP_CLKS(GAP_CLKS),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_go),
    .sel_i      (sel_i),
    .rst_en_i   (rst_en_q),
    .flag_clr_i (ctrl_we_i && flag_clr_i),
    .stat_clr_i (ctrl_we_i && stat_clr_i),
    .flag_o     (irq_flag_o),
    .rst_pulse_o(cpu_rst_o),
    .stat_o     (wd_rst_stat_o)
  );

  assign irq_o    = irq_flag_o && irq_en_q;
  assign rst_en_o = rst_en_q;
endmodule

// File: rtl/wdt_pre_irq_chk.sv
module wdt_pre_irq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ctrl_we_i,
  input logic flag_clr_i,
  input logic irq_o,
  input logic irq_flag_o,
  input logic cpu_rst_o,
  input logic wd_rst_stat_o,
  input logic rst_en_o
);
  // R5
  rst_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |=> !cpu_rst_o);
  // R5
  rst_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |-> $past(rst_en_o));
  // R6
  stat_with_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |-> wd_rst_stat_o);
  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !(ctrl_we_i && flag_clr_i)) |=> irq_flag_o);
  // R3
  irq_has_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_flag_o);
  // R8
  rst_en_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_en_o) |-> $past(ctrl_we_i));
endmodule

bind wdt_pre_irq wdt_pre_irq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .flag_clr_i   (flag_clr_i),
  .irq_o        (irq_o),
  .irq_flag_o   (irq_flag_o),
  .cpu_rst_o    (cpu_rst_o),
  .wd_rst_stat_o(wd_rst_stat_o),
  .rst_en_o     (rst_en_o)
);

// File: tb/wdt_pre_irq_tb.sv
`timescale 1ns/1ps
module wdt_pre_irq_tb;
  localparam int unsigned BASE = 6;
  localparam int unsigned STEP = 1;
  localparam int unsigned GAP  = 8;
  localparam int T0 = 1 << BASE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_we = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic       ctrl_we = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       irq_en = 1'b0, rst_en = 1'b0, restart = 1'b0;
  logic       fclr = 1'b0, sclr = 1'b0;
  logic       irq, flag, cpu_rst, stat, rst_en_out;

  int checks = 0, fails = 0, rst_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_pre_irq #(.BASE_EXP(BASE), .EXP_STEP(STEP), .GAP_CLKS(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .key_we_i(key_we), .key_data_i(key_data),
    .ctrl_we_i(ctrl_we), .sel_i(sel), .irq_en_i(irq_en), .rst_en_i(rst_en),
    .restart_i(restart), .flag_clr_i(fclr), .stat_clr_i(sclr),
    .irq_o(irq), .irq_flag_o(flag), .cpu_rst_o(cpu_rst),
    .wd_rst_stat_o(stat), .rst_en_o(rst_en_out)
  );

  always @(negedge clk) if (cpu_rst) rst_seen++;

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    key_we = 1'b1; key_data = 8'hAA; @(negedge clk);
    key_data = 8'h55; @(negedge clk);
    key_we = 1'b0; key_data = 8'h00;
  endtask

  task automatic cwrite(input logic [1:0] s, input logic ie, input logic re,
                        input logic rs, input logic fc, input logic sc);
    sel = s; irq_en = ie; rst_en = re; restart = rs; fclr = fc; sclr = sc;
    ctrl_we = 1'b1; @(negedge clk);
    ctrl_we = 1'b0; restart = 1'b0; fclr = 1'b0; sclr = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 irq", irq, 0); chk("R1 flag", flag, 0); chk("R1 cpu_rst", cpu_rst, 0);
    chk("R1 stat", stat, 0); chk("R1 rst_en", rst_en_out, 0);
    wait_n(T0 - 1); chk("R1 flag before first timeout", flag, 0);
    wait_n(1);      chk("R1 flag at first timeout", flag, 1);
  endtask

  task automatic t_select();
    for (int s = 0; s < 4; s++) begin
      int t = T0 << s;
      unlock(); cwrite(2'(s), 1, 0, 1, 1, 0);
      wait_n(t - 1);
      chk($sformatf("R2 sel=%0d flag early", s), flag, 0);
      chk("R3 irq early", irq, 0);
      wait_n(1);
      chk($sformatf("R2 sel=%0d flag on time", s), flag, 1);
      chk("R3 irq on time", irq, 1);
    end
  endtask

  task automatic t_irq_mask();
    unlock(); cwrite(0, 0, 0, 1, 1, 0);
    wait_n(T0);
    chk("R3 flag set while masked", flag, 1);
    chk("R3 irq masked", irq, 0);
    cwrite(0, 1, 0, 0, 0, 0);
    chk("R3 irq after enable", irq, 1);
    cwrite(0, 1, 0, 0, 1, 0);
    chk("R4 flag cleared", flag, 0);
  endtask

  task automatic t_clear_collision();
    unlock(); cwrite(0, 1, 0, 1, 1, 0);
    wait_n(T0 - 1);
    cwrite(0, 1, 0, 0, 1, 0);  // clear lands on the time-out clock
    chk("R4 set wins over clear", flag, 1);
    cwrite(0, 1, 0, 0, 1, 0);
    chk("R4 later clear", flag, 0);
  endtask

  task automatic t_reset_fire();
    int base;
    unlock(); cwrite(0, 1, 1, 1, 1, 1);
    chk("R8 rst_en accepted", rst_en_out, 1);
    base = rst_seen;
    wait_n(T0 + GAP - 1);
    chk("R5 no pulse early", cpu_rst, 0); chk("R6 stat early", stat, 0);
    wait_n(1);
    chk("R5 pulse", cpu_rst, 1); chk("R6 stat set", stat, 1);
    wait_n(1);
    chk("R5 pulse one clock", cpu_rst, 0);
    chk("R5 pulse count", rst_seen - base, 1);
    cwrite(0, 1, 1, 0, 1, 0);
    wait_n(T0 - 3); chk("R5 restarted count early", flag, 0);
    wait_n(1);      chk("R5 restarted count on time", flag, 1);
    cwrite(0, 1, 1, 0, 0, 1);
    chk("R6 stat cleared", stat, 0);
    unlock(); cwrite(0, 1, 0, 1, 1, 0);
    chk("R8 rst_en off", rst_en_out, 0);
  endtask

  task automatic t_timebase();
    int base;
    unlock(); cwrite(0, 1, 0, 1, 1, 0);
    base = rst_seen;
    wait_n(T0); chk("R7 first flag", flag, 1);
    cwrite(0, 1, 0, 0, 1, 0);
    wait_n(T0 + GAP - 2); chk("R7 period early", flag, 0);
    wait_n(1);            chk("R7 period on time", flag, 1);
    chk("R7 no reset pulse", rst_seen - base, 0);
  endtask

  task automatic t_access();
    cwrite(0, 1, 1, 1, 0, 0);
    chk("R8 locked write ignored", rst_en_out, 0);
    unlock(); wait_n(4); cwrite(0, 1, 1, 1, 0, 0);
    chk("R8 late write ignored", rst_en_out, 0);
    unlock(); wait_n(3); cwrite(0, 1, 1, 1, 1, 0);
    chk("R8 last window clock accepted", rst_en_out, 1);
    unlock(); cwrite(0, 1, 0, 1, 1, 0);
    chk("R8 disable accepted", rst_en_out, 0);
    unlock(); cwrite(0, 1, 0, 0, 0, 0); cwrite(0, 1, 1, 1, 0, 0);
    chk("R8 window consumed", rst_en_out, 0);
    key_we = 1'b1; key_data = 8'hAA; @(negedge clk);
    key_we = 1'b0; @(negedge clk);
    key_we = 1'b1; key_data = 8'h55; @(negedge clk);
    key_we = 1'b0;
    cwrite(0, 1, 1, 1, 0, 0);
    chk("R9 gapped key ignored", rst_en_out, 0);
    key_we = 1'b1; key_data = 8'h55; @(negedge clk);
    key_data = 8'hAA; @(negedge clk);
    key_we = 1'b0;
    cwrite(0, 1, 1, 1, 0, 0);
    chk("R9 reversed key ignored", rst_en_out, 0);
  endtask

  task automatic t_sel_no_restart();
    unlock(); cwrite(0, 1, 0, 1, 1, 0);
    cwrite(3, 1, 0, 1, 0, 0);  // locked: restart and select change ignored
    wait_n(T0 - 2); chk("R10 period kept early", flag, 0);
    wait_n(1);      chk("R10 period kept on time", flag, 1);
  endtask

  task automatic t_collision();
    int base;
    unlock(); cwrite(0, 1, 1, 1, 1, 1);
    base = rst_seen;
    wait_n(T0 + GAP - 3);
    unlock(); cwrite(0, 1, 1, 1, 1, 0);  // restart lands on the firing clock
    chk("R11 no pulse", cpu_rst, 0);
    chk("R11 flag cleared", flag, 0);
    wait_n(2);
    chk("R11 pulse count", rst_seen - base, 0);
    chk("R11 stat clear", stat, 0);
    wait_n(T0 - 3); chk("R11 new count early", flag, 0);
    wait_n(1);      chk("R11 new count on time", flag, 1);
    unlock(); cwrite(0, 1, 0, 1, 1, 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    t_reset_state();
    t_select();
    t_irq_mask();
    t_clear_collision();
    t_reset_fire();
    t_timebase();
    t_access();
    t_sel_no_restart();
    t_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule